// File: doc/BRIEF.md
# Floppy Disk Write Serializer

This block turns bytes written by a host into the serial bit stream that records onto a floppy drive. Writing takes place only while both mode controls, q7 and q6, are high. A one-byte holding register takes the host's byte. A shift register sends its bits out most significant bit first, one bit cell at a time. The length of a bit cell follows the media type: a byte lasts 32 reference cycles on 5.25-inch media and 16 on 3.5-inch media. When the last bit of a byte has gone out, the next byte moves from the holding register into the shifter with no idle cell between them. Because bits are packed with no gaps, a run of ordinary 8-bit writes can form longer self-sync fields. The five bytes FF, 3F, CF, F3, FC together make four 10-bit sync nibbles.

In asynchronous mode the stream stops when the holding register is empty at a byte boundary, and an underrun flag is raised. In synchronous mode the shifter fills such a gap with whole bytes of zero cells and keeps the drive write-enabled. It picks up the next host byte at a later byte boundary. A small recorder regroups the bit stream into nibbles as they would land on the track. Its length is clamped, its top bit is forced to one, and a partial byte cut short by leaving write mode is reported. This recorder gives the bench, and any track model, a view of what was written.

Top module: `fdc_write_shifter`

## Requirements
- R1: The holding register accepts a host strobe only while q7=1 and q6=1. Outside that mode, wr_en and buf_ready are 0, and a strobe given there leaves nothing queued.
- R2: On 5.25-inch media (media35=0) each bit cell lasts 4 cycles. The first cell begins one cycle after a byte is taken into an idle shifter. Bits go out most significant first on wr_bit, and wr_en is 1 while shifting.
- R3: On 3.5-inch media (media35=1) each bit cell lasts 2 cycles, with the same bit order and start rule as R2.
- R4: Consecutive bytes are packed with no gap between them. Writing FF, 3F, CF, F3, FC with each byte supplied as soon as buf_ready allows keeps wr_en high for exactly 40 cells. The recorder reports four nibbles, each with byte FF and length 10.
- R5: buf_ready goes 0 in the cycle after a host write and returns to 1 in the cycle after that byte moves into the shifter.
- R6: In asynchronous mode (sync_mode=0), if the last cell of a byte ends while the holding register is empty, wr_en drops and underrun is set. A later host write clears underrun.
- R7: In synchronous mode (sync_mode=1), an empty holding register at a byte boundary produces a byte of zero cells. wr_en stays 1 and underrun stays 0, and a byte written during the fill is loaded at the next byte boundary.
- R8: Leaving write mode during a byte drops wr_en on the next cycle. The recorder then reports only the completed cells, right-aligned, with bit 7 forced to 1 and the length equal to the number of cells.
- R9: A recorded nibble is 1 to 10 cells long. Any longer run of zero cells that follows a nibble is reported as length 10.
- R10: Every recorded nibble has bit 7 set. A nibble whose first cell was 0 is reported with that bit forced to 1.
- R11: After reset, wr_bit, wr_en, buf_ready, underrun and nib_stb are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q6 | input | 1 | Mode control; write mode needs q6=1 and q7=1 |
| q7 | input | 1 | Mode control |
| sync_mode | input | 1 | 1 selects synchronous write mode, 0 asynchronous |
| media35 | input | 1 | 1 selects 3.5-inch cell timing, 0 selects 5.25-inch |
| wr_stb | input | 1 | One-cycle host write strobe |
| wr_data | input | 8 | Host byte |
| wr_bit | output | 1 | Serial write data to the drive |
| wr_en | output | 1 | Drive write enable |
| buf_ready | output | 1 | Holding register empty, ready for the next byte |
| underrun | output | 1 | Asynchronous shifter ran dry |
| nib_stb | output | 1 | One-cycle pulse: a recorded nibble is complete |
| nib_byte | output | 8 | Recorded nibble value |
| nib_len | output | 4 | Recorded nibble length in cells |

## Verification
A byte strobed into an idle shifter shows its first bit one cycle after the strobe cycle. Each later bit moves after 4 cycles on 5.25-inch media or 2 cycles on 3.5-inch media. The bench counts negative edges from that start cycle and compares wr_bit against the bit that cell index selects. buf_ready is due to fall on the first edge after the strobe and to rise on the edge that starts the shift. underrun and the fall of wr_en are due on the edge that closes the last cell. A recorded nibble appears two cycles after the stream stops, so the bench waits a fixed margin before it compares the list of nibbles it captured.

// File: rtl/fdc_write_shifter.sv
module fdc_write_shifter #(
  parameter int BYTE_CYC_525 = 32,
  parameter int BYTE_CYC_35  = 16,
  parameter int NIB_MAX      = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       q6,
  input  logic       q7,
  input  logic       sync_mode,
  input  logic       media35,
  input  logic       wr_stb,
  input  logic [7:0] wr_data,
  output logic       wr_bit,
  output logic       wr_en,
  output logic       buf_ready,
  output logic       underrun,
  output logic       nib_stb,
  output logic [7:0] nib_byte,
  output logic [3:0] nib_len
);
  localparam int CELL_525 = BYTE_CYC_525 / 8;
  localparam int CELL_35  = BYTE_CYC_35 / 8;
  localparam int CELL_MAX = (CELL_525 > CELL_35) ? CELL_525 : CELL_35;
  localparam int CW       = $clog2(CELL_MAX) + 1;
  localparam logic [CW-1:0] LAST_525 = CW'(CELL_525 - 1);
  localparam logic [CW-1:0] LAST_35  = CW'(CELL_35 - 1);
  localparam logic [3:0]    LEN_CAP  = 4'(NIB_MAX);

  logic          active, hold_full, fl_q;
  logic [7:0]    hold, sh;
  logic [3:0]    bits_left;
  logic [CW-1:0] cnt;

  logic wr_mode, start, cell_end, byte_end, load, stb_ok, ending;

  assign wr_mode   = q7 & q6;
  assign stb_ok    = wr_mode & wr_stb;
  assign start     = wr_mode & ~active & hold_full;
  assign cell_end  = active & (cnt == (media35 ? LAST_35 : LAST_525));
  assign byte_end  = cell_end & (bits_left == 4'd1);
  assign load      = start | (byte_end & hold_full);
  assign ending    = active & (~wr_mode | (byte_end & ~hold_full & ~sync_mode));

  assign wr_en     = active;
  assign wr_bit    = active & sh[7];
  assign buf_ready = wr_mode & ~hold_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0; hold_full <= 1'b0; underrun <= 1'b0;
      hold <= '0; sh <= '0; bits_left <= '0; cnt <= '0;
    end else if (!wr_mode) begin
      active <= 1'b0; hold_full <= 1'b0; underrun <= 1'b0; cnt <= '0;
    end else begin
      if (stb_ok) hold <= wr_data;
      hold_full <= (hold_full & ~load) | stb_ok;
      if (stb_ok) underrun <= 1'b0;
      else if (byte_end & ~hold_full & ~sync_mode) underrun <= 1'b1;
      if (load) begin
        sh <= hold; bits_left <= 4'd8; cnt <= '0; active <= 1'b1;
      end else if (byte_end & sync_mode) begin
        sh <= '0; bits_left <= 4'd8; cnt <= '0;
      end else if (byte_end) begin
        active <= 1'b0; cnt <= '0;
      end else if (cell_end) begin
        sh <= {sh[6:0], 1'b0}; bits_left <= bits_left - 4'd1; cnt <= '0;
      end else if (active) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // nibble recorder: regroups the written cells as they land on the track
  logic       nopen, o_n, emit;
  logic [3:0] ncnt, c_n, ec;
  logic [7:0] ndat, d_n, eb;
  logic       samp;

  assign samp = cell_end & wr_mode;

  always_comb begin
    o_n = nopen; c_n = ncnt; d_n = ndat;
    emit = 1'b0; eb = ndat; ec = ncnt;
    if (fl_q) begin
      emit = nopen; o_n = 1'b0; c_n = '0; d_n = '0;
    end else if (samp) begin
      if (nopen && ncnt >= 4'd8 && sh[7]) begin
        emit = 1'b1; c_n = 4'd1; d_n = {7'b0, sh[7]};
      end else if (!nopen) begin
        o_n = 1'b1; c_n = 4'd1; d_n = {7'b0, sh[7]};
      end else begin
        if (ncnt < 4'd8) d_n = {ndat[6:0], sh[7]};
        if (ncnt != 4'd15) c_n = ncnt + 4'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nopen <= 1'b0; ncnt <= '0; ndat <= '0; fl_q <= 1'b0;
      nib_stb <= 1'b0; nib_byte <= '0; nib_len <= '0;
    end else begin
      nopen <= o_n; ncnt <= c_n; ndat <= d_n;
      fl_q <= ending;
      nib_stb <= emit;
      if (emit) begin
        nib_byte <= eb | 8'h80;
        nib_len  <= (ec > LEN_CAP) ? LEN_CAP : ec;
      end
    end
  end
endmodule

module fdc_write_shifter_chk #(
  parameter int NIB_MAX = 10
) (
  input logic       clk,
  input logic       rst_n,
  input logic       q6,
  input logic       q7,
  input logic       sync_mode,
  input logic       wr_stb,
  input logic       wr_en,
  input logic       buf_ready,
  input logic       underrun,
  input logic       nib_stb,
  input logic [7:0] nib_byte,
  input logic [3:0] nib_len
);
  // R1
  wr_en_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(q7 && q6) |=> !wr_en);
  // R1
  ready_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_ready |-> (q7 && q6));
  // R5
  ready_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q7 && q6 && wr_stb) |=> !buf_ready);
  // R6
  underrun_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> !wr_en);
  // R7
  sync_no_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> !$past(sync_mode));
  // R9
  nib_len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nib_stb |-> (nib_len != 4'd0 && nib_len <= 4'(NIB_MAX)));
  // R10
  nib_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nib_stb |-> nib_byte[7]);
endmodule

bind fdc_write_shifter fdc_write_shifter_chk #(.NIB_MAX(NIB_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .q6(q6), .q7(q7), .sync_mode(sync_mode),
  .wr_stb(wr_stb), .wr_en(wr_en), .buf_ready(buf_ready), .underrun(underrun),
  .nib_stb(nib_stb), .nib_byte(nib_byte), .nib_len(nib_len));

// File: tb/sim_fdc_write_shifter.sv
`timescale 1ns/1ps
module sim_fdc_write_shifter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic q6 = 1'b0, q7 = 1'b0, sync_mode = 1'b0, media35 = 1'b0, wr_stb = 1'b0;
  logic [7:0] wr_data = '0;
  logic wr_bit, wr_en, buf_ready, underrun, nib_stb;
  logic [7:0] nib_byte;
  logic [3:0] nib_len;

  int n_cmp = 0, n_bad = 0;
  int nb_n = 0;
  logic [7:0] nb_b [64];
  logic [3:0] nb_l [64];

  always #2.5 clk = ~clk;

  fdc_write_shifter u0 (.*);

  always @(negedge clk)
    if (nib_stb && nb_n < 64) begin
      nb_b[nb_n] = nib_byte; nb_l[nb_n] = nib_len; nb_n = nb_n + 1;
    end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [7:0] d);
    wr_data = d; wr_stb = 1'b1;
    @(negedge clk); wr_stb = 1'b0;
  endtask

  // {media35, byte}
  localparam logic [8:0] VEC [6] = '{9'h0A5, 9'h1A5, 9'h03C, 9'h1D5, 9'h001, 9'h180};

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11
    chk(!wr_en && !wr_bit && !buf_ready && !underrun && !nib_stb, "R11 reset",
        {wr_en, wr_bit, buf_ready, underrun, nib_stb}, 0);

    // R1: strobe outside write mode is dropped
    q7 = 1'b1; q6 = 1'b0;
    @(negedge clk);
    strobe(8'hFF);
    chk(!buf_ready && !wr_en, "R1 outside mode", {buf_ready, wr_en}, 0);
    q6 = 1'b1;
    @(negedge clk);
    chk(buf_ready, "R1 nothing queued", buf_ready, 1);
    repeat (8) @(negedge clk);
    chk(!wr_en, "R1 no stream", wr_en, 0);

    // vector walk: R2 / R3 / R5 / R6
    for (int v = 0; v < 6; v++) begin
      int per;
      logic [7:0] b;
      media35 = VEC[v][8]; b = VEC[v][7:0];
      per = media35 ? 2 : 4;
      strobe(b);
      chk(!buf_ready, "R5 busy after write", buf_ready, 0);
      @(negedge clk);
      chk(buf_ready, "R5 ready after load", buf_ready, 1);
      for (int j = 0; j < 8 * per; j++) begin
        if (j > 0) @(negedge clk);
        chk(wr_en && wr_bit == b[7 - j / per], media35 ? "R3 cell" : "R2 cell",
            {wr_en, wr_bit}, {1'b1, b[7 - j / per]});
      end
      @(negedge clk);
      chk(!wr_en && underrun, "R6 underrun", {wr_en, underrun}, 2'b01);
    end
    strobe(8'h00);
    chk(!underrun, "R6 cleared by write", underrun, 0);
    q7 = 1'b0;
    repeat (40) @(negedge clk);

    // R4: five bytes packed into four sync nibbles
    begin
      logic [7:0] seq [5];
      int k, hi, st, mark;
      bit started;
      seq = '{8'hFF, 8'h3F, 8'hCF, 8'hF3, 8'hFC};
      media35 = 1'b0; sync_mode = 1'b0; q7 = 1'b1; q6 = 1'b1;
      mark = nb_n; k = 0; hi = 0; started = 0;
      repeat (400) begin
        @(negedge clk);
        if (wr_en) begin hi++; started = 1; end
        else if (started) break;
        if (buf_ready && k < 5) begin wr_data = seq[k]; wr_stb = 1'b1; k++; end
        else wr_stb = 1'b0;
      end
      wr_stb = 1'b0;
      chk(hi == 160, "R4 continuous cells", hi, 160);
      repeat (4) @(negedge clk);
      chk(nb_n - mark == 4, "R4 nibble count", nb_n - mark, 4);
      st = 0;
      for (int i = 0; i < 4; i++)
        if (nb_b[mark + i] != 8'hFF || nb_l[mark + i] != 4'd10) st++;
      chk(st == 0, "R4 sync nibbles", st, 0);
    end

    // R9: zeros after a nibble clamp its length
    begin
      int mark;
      mark = nb_n;
      strobe(8'hFF);
      while (!buf_ready) @(negedge clk);
      strobe(8'h00);
      while (wr_en || buf_ready == 1'b0) @(negedge clk);
      repeat (4) @(negedge clk);
      chk(nb_n - mark == 1 && nb_b[mark] == 8'hFF && nb_l[mark] == 4'd10, "R9 clamp",
          {nb_b[mark], nb_l[mark]}, 12'hFFA);
    end

    // R10: leading zero cell forced to one
    begin
      int mark;
      mark = nb_n;
      strobe(8'h7F);
      while (!buf_ready) @(negedge clk);
      strobe(8'hFF);
      while (wr_en || buf_ready == 1'b0) @(negedge clk);
      repeat (4) @(negedge clk);
      chk(nb_n - mark == 2, "R10 count", nb_n - mark, 2);
      chk(nb_b[mark] == 8'hFF && nb_l[mark] == 4'd8, "R10 msb forced",
          {nb_b[mark], nb_l[mark]}, 12'hFF8);
      chk(nb_b[mark + 1] == 8'hFF && nb_l[mark + 1] == 4'd8, "R10 second",
          {nb_b[mark + 1], nb_l[mark + 1]}, 12'hFF8);
    end

    // R8: partial byte when write mode is left
    begin
      int mark;
      mark = nb_n;
      strobe(8'hA5);
      for (int j = 0; j <= 13; j++) @(negedge clk);
      q7 = 1'b0;
      @(negedge clk);
      chk(!wr_en && !wr_bit, "R8 stop at once", {wr_en, wr_bit}, 0);
      repeat (4) @(negedge clk);
      chk(nb_n - mark == 1 && nb_b[mark] == 8'h85 && nb_l[mark] == 4'd3, "R8 partial",
          {nb_b[mark], nb_l[mark]}, 12'h853);
    end

    // R7: synchronous zero fill and boundary load
    begin
      int mark;
      logic [7:0] b;
      q7 = 1'b1; sync_mode = 1'b1; media35 = 1'b1;
      @(negedge clk);
      mark = nb_n;
      strobe(8'hC3);
      @(negedge clk);
      for (int j = 0; j < 53; j++) begin
        if (j > 0) @(negedge clk);
        if (j == 20) begin wr_data = 8'h81; wr_stb = 1'b1; end
        else wr_stb = 1'b0;
        b = (j < 16) ? 8'hC3 : (j < 32) ? 8'h00 : (j < 48) ? 8'h81 : 8'h00;
        if (j < 48 || j == 52) begin
          if (wr_bit != b[7 - (j % 16) / 2] || !wr_en || underrun)
            chk(0, "R7 sync stream", {wr_en, underrun, wr_bit}, {2'b10, b[7 - (j % 16) / 2]});
        end
      end
      n_cmp++;
      chk(wr_en && !underrun, "R7 still enabled", {wr_en, underrun}, 2'b10);
      q7 = 1'b0;
      repeat (6) @(negedge clk);
      chk(nb_n - mark == 2, "R7 nibble count", nb_n - mark, 2);
      chk(nb_b[mark] == 8'hC3 && nb_l[mark] == 4'd10, "R7 first nibble",
          {nb_b[mark], nb_l[mark]}, 12'hC3A);
      chk(nb_b[mark + 1] == 8'h81 && nb_l[mark + 1] == 4'd10, "R7 loaded byte",
          {nb_b[mark + 1], nb_l[mark + 1]}, 12'h81A);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule